// File: doc/BRIEF.md
# Memory Partition Address Mapper

This block sits after the address field decode in a memory subsystem. A request arrives already split into a channel index, a bank index and a field of high-order address bits. The block turns these into the sub-partition that finally serves the request and the channel that owns that sub-partition. A two-bit mode picks how the mapping is done. Pass-through keeps the decoded channel. XOR permutation folds low high-order bits into the channel number. Polynomial hashing spreads a combined channel/sub-partition identifier over a power-of-two space using carry-less (GF(2)) residues of the high bits.

The channel count does not have to be a power of two. For polynomial hashing, the hash space is the channel count rounded up to the next power of two, times the sub-partitions per channel. Any result that lands beyond the real number of sub-partitions is folded back into range. One register stage with a valid/ready handshake holds the result. A registered error flag marks requests whose mode is not legal for the configuration or whose result is out of range.

Top module: `part_addr_mapper`

## Requirements
- R1: After reset, out_valid and out_err are 0 and in_ready is 1.
- R2: in_ready equals (not out_valid) or out_ready. A request taken at a rising edge (in_valid and in_ready high) shows on the outputs with out_valid high right after that same edge.
- R3: While out_valid is 1 and out_ready is 0, out_valid, out_subpart, out_chan and out_err keep their values, and no new request is taken.
- R4: Mode 2'b00 (pass-through) gives out_subpart = in_chan * SUB_PER_CH + (in_bank mod SUB_PER_CH) and out_chan = in_chan. No fold is applied.
- R5: Mode 2'b01 (XOR permutation) first forms c = in_chan XOR (in_hi mod NUM_CH). It then gives out_subpart = c * SUB_PER_CH + (in_bank mod SUB_PER_CH). The mode is legal only when NUM_CH is a power of two.
- R6: Mode 2'b10 (polynomial hash) starts from id = in_chan * SUB_PER_CH + (in_bank mod SUB_PER_CH), a W-bit value where W = log2 of the hash space. It XORs into id the residue x^(W+i) mod P for every set bit i of in_hi, with P = x^5+x^2+1 for W = 5. For the default configuration, each output bit h_k is c_k XORed with these high bits a_i: h0: a0,a3,a5,a6,a9,a10,a11,a12,a13; h1: a1,a4,a6,a7,a10,a11,a12,a13,a14; h2: a0,a2,a3,a6,a7,a8,a9,a10,a14; h3: a1,a3,a4,a7,a8,a9,a10,a11; h4: a2,a4,a5,a8,a9,a10,a11,a12.
- R7: The hash space is next_pow2(NUM_CH) * SUB_PER_CH, where next_pow2(n) = n if n is a power of two. A hashed value at or above NUM_CH * SUB_PER_CH has that total subtracted, so mode 2'b10 never raises out_err.
- R8: In every mode, out_chan = out_subpart / SUB_PER_CH.
- R9: out_err is 1 in any of three cases: the mode is 2'b11; the mode is 2'b01 while NUM_CH is not a power of two; or out_subpart >= NUM_CH * SUB_PER_CH. Otherwise out_err is 0.
- R10: With a power-of-two channel count in mode 2'b10, fix in_chan and in_bank and set in_hi = j * 2^n. The 2^W values of j then give 2^W distinct out_subpart values, for every n with the stride still inside in_hi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_mode | input | 2 | 00 pass-through, 01 XOR permutation, 10 polynomial hash, 11 reserved |
| in_chan | input | CH_W | Decoded channel index |
| in_bank | input | BANK_W | Decoded bank index |
| in_hi | input | HI_W | High-order address bits |
| out_valid | output | 1 | Result held in the output stage |
| out_ready | input | 1 | Consumer takes the result |
| out_chan | output | CH_W | Final channel |
| out_subpart | output | SP_W | Final sub-partition |
| out_err | output | 1 | Illegal mode or out-of-range result |

## Verification
Any fault in the mapping logic shows up in the output register one cycle after the request is taken. It appears as a wrong out_subpart, as an out_chan that no longer matches out_subpart, or as out_err raised or missing. A fold that is skipped or misplaced shows only in hash mode. There it gives out_err or a sub-partition at or above the total, for about a quarter of random addresses in the default twelve-channel setup. A residue with one bit wrong shows as a repeated sub-partition in the stride sweep, within one period of the affected stride. A fault in the stall logic shows as in_ready high, or a changed output, on the first stalled cycle.

// File: rtl/pam_pkg.sv
// Shared definitions for the partition address mapper.
// Assumes the polynomial hash width is between 1 and 8 bits.
package pam_pkg;

    typedef enum logic [1:0] {
        MAP_PASS = 2'b00,
        MAP_XOR  = 2'b01,
        MAP_POLY = 2'b10,
        MAP_RSVD = 2'b11
    } map_mode_e;

    // Smallest power of two not below n (n itself when already a power of two).
    function automatic int next_pow2(input int n);
        int p;
        p = 1;
        for (int i = 0; i < 31; i++) begin
            if (p < n) p = p * 2;
        end
        return p;
    endfunction

    // Irreducible polynomial per hash width, with the x^w term included.
    function automatic int hash_poly(input int w);
        case (w)
            1:       return 3;
            2:       return 7;
            3:       return 11;
            4:       return 19;
            5:       return 37;
            6:       return 67;
            7:       return 131;
            default: return 285;
        endcase
    endfunction

    // Residue of x^(w+k) modulo the width-w polynomial, as a w-bit vector.
    function automatic logic [31:0] poly_residue(input int w, input int k);
        logic [31:0] r;
        logic [31:0] msk;
        logic [31:0] low;
        logic        carry;
        msk = (32'd1 << w) - 32'd1;
        low = 32'(hash_poly(w)) & msk;
        r   = 32'd1;
        for (int s = 0; s < w + k; s++) begin
            carry = r[w-1];
            r     = (r << 1) & msk;
            if (carry) r = r ^ low;
        end
        return r;
    endfunction

endpackage

// File: rtl/pam_xor_perm.sv
// XOR permutation of the channel index with the low high-order bits.
// Assumes the channel count is a power of two, so masking to the channel
// width equals reduction modulo the channel count.
module pam_xor_perm #(
    parameter int CH_W = 4,
    parameter int HI_W = 15
) (
    input  logic [CH_W-1:0] chan_i,
    input  logic [HI_W-1:0] hi_i,
    output logic [CH_W-1:0] chan_o
);
    logic [CH_W-1:0] hi_low;

    // Pick or widen the high bits to the channel width.
    generate
        if (HI_W >= CH_W) begin : g_trunc
            assign hi_low = CH_W'(hi_i);
        end else begin : g_widen
            assign hi_low = {{(CH_W-HI_W){1'b0}}, hi_i};
        end
    endgenerate

    // Permute the channel.
    assign chan_o = chan_i ^ hi_low;
endmodule

// File: rtl/pam_poly_hash.sv
// Carry-less polynomial hash: XORs into the identifier one precomputed
// residue x^(OUT_W+i) mod P for every set high-order bit i.
// Assumes OUT_W is between 1 and 8.
module pam_poly_hash #(
    parameter int OUT_W = 5,
    parameter int HI_W  = 15
) (
    input  logic [OUT_W-1:0] id_i,
    input  logic [HI_W-1:0]  hi_i,
    output logic [OUT_W-1:0] hash_o
);
    logic [OUT_W-1:0] term [HI_W];

    // One gated residue per high-order bit.
    generate
        for (genvar gi = 0; gi < HI_W; gi++) begin : g_term
            localparam logic [31:0] RES = pam_pkg::poly_residue(OUT_W, gi);
            assign term[gi] = hi_i[gi] ? RES[OUT_W-1:0] : '0;
        end
    endgenerate

    // XOR-reduce the residues onto the identifier.
    always_comb begin
        hash_o = id_i;
        for (int i = 0; i < HI_W; i++) begin
            hash_o = hash_o ^ term[i];
        end
    end
endmodule

// File: rtl/pam_fold.sv
// Folds a value from the power-of-two hash space back under TOTAL.
// Assumes the value is below 2*TOTAL, which holds because the rounded
// channel count is less than twice the real one.
module pam_fold #(
    parameter int W     = 5,
    parameter int TOTAL = 24
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] val_o
);
    generate
        if (TOTAL == (1 << W)) begin : g_exact
            // Space already matches the total: nothing to fold.
            assign val_o = val_i;
        end else begin : g_sub
            localparam logic [W-1:0] TOT_V = W'(TOTAL);
            // One conditional subtract covers the whole overshoot.
            assign val_o = (val_i >= TOT_V) ? (val_i - TOT_V) : val_i;
        end
    endgenerate
endmodule

// File: rtl/part_addr_mapper.sv
// Maps a decoded channel, bank and high-address field to a final
// sub-partition and channel, in one of three modes, behind one
// valid/ready register stage. Assumes SUB_PER_CH is a power of two,
// NUM_CH >= 2 and the hash width is at most 8 bits.
module part_addr_mapper #(
    parameter int NUM_CH     = 12,
    parameter int SUB_PER_CH = 2,
    parameter int BANK_W     = 4,
    parameter int HI_W       = 15,
    localparam int P2_CH     = pam_pkg::next_pow2(NUM_CH),
    localparam int CH_W      = $clog2(P2_CH),
    localparam int SUB_W     = $clog2(SUB_PER_CH),
    localparam int SP_W      = CH_W + SUB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_mode,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [HI_W-1:0]   in_hi,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CH_W-1:0]   out_chan,
    output logic [SP_W-1:0]   out_subpart,
    output logic              out_err
);
    import pam_pkg::*;

    localparam int          TOTAL    = NUM_CH * SUB_PER_CH;
    localparam bit          CH_POW2  = (P2_CH == NUM_CH);
    localparam logic [SP_W:0]   TOTAL_V  = (SP_W+1)'(TOTAL);
    localparam logic [SP_W-1:0] SUB_MASK = SP_W'(SUB_PER_CH - 1);

    map_mode_e       mode;
    logic [SP_W-1:0] bank_lo;
    logic [SP_W-1:0] id_pass;
    logic [CH_W-1:0] xor_chan;
    logic [SP_W-1:0] id_xor;
    logic [SP_W-1:0] hash_raw;
    logic [SP_W-1:0] hash_fold;
    logic [SP_W-1:0] sub_d;
    logic            err_d;
    logic            load;
    logic            vld_q;
    logic [SP_W-1:0] sub_q;
    logic            err_q;

    // Decode the mode and build the combined identifiers.
    assign mode    = map_mode_e'(in_mode);
    assign bank_lo = SP_W'(in_bank) & SUB_MASK;
    assign id_pass = (SP_W'(in_chan) << SUB_W) | bank_lo;
    assign id_xor  = (SP_W'(xor_chan) << SUB_W) | bank_lo;

    pam_xor_perm #(.CH_W(CH_W), .HI_W(HI_W)) xor_i (
        .chan_i (in_chan),
        .hi_i   (in_hi),
        .chan_o (xor_chan)
    );

    pam_poly_hash #(.OUT_W(SP_W), .HI_W(HI_W)) hash_i (
        .id_i   (id_pass),
        .hi_i   (in_hi),
        .hash_o (hash_raw)
    );

    pam_fold #(.W(SP_W), .TOTAL(TOTAL)) fold_i (
        .val_i (hash_raw),
        .val_o (hash_fold)
    );

    // Select the result per mode and flag illegal or out-of-range cases.
    always_comb begin
        err_d = 1'b0;
        case (mode)
            MAP_XOR: begin
                sub_d = id_xor;
                if (!CH_POW2) err_d = 1'b1;
            end
            MAP_POLY: sub_d = hash_fold;
            MAP_RSVD: begin
                sub_d = id_pass;
                err_d = 1'b1;
            end
            default:  sub_d = id_pass;
        endcase
        if ({1'b0, sub_d} >= TOTAL_V) err_d = 1'b1;
    end

    // Handshake: accept when the stage is empty or being drained.
    assign in_ready = !vld_q || out_ready;
    assign load     = in_valid && in_ready;

    // Output stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            sub_q <= '0;
            err_q <= 1'b0;
        end else if (load) begin
            vld_q <= 1'b1;
            sub_q <= sub_d;
            err_q <= err_d;
        end else if (out_ready) begin
            vld_q <= 1'b0;
        end
    end

    assign out_valid   = vld_q;
    assign out_subpart = sub_q;
    assign out_chan    = sub_q[SP_W-1:SUB_W];
    assign out_err     = err_q;

    // R2: a stalled input only happens when a result waits unconsumed.
    p_ready_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready));

    // R2: an accepted request is presented in the next cycle.
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R3: a stalled result does not change.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_subpart) && $stable(out_err)));

    // R4: pass-through keeps the channel.
    p_pass_chan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_mode == 2'b00) |=> (out_chan == $past(in_chan)));

    // R7: the fold always brings hashed results into range.
    p_poly_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_mode == 2'b10) |=> !out_err);

    // R9: the reserved mode is always flagged.
    p_rsvd_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_mode == 2'b11) |=> out_err);
endmodule

// File: tb/part_addr_mapper_tb_top.sv
`timescale 1ns/1ps
module part_addr_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready, in_ready_p2;
    logic [1:0]  in_mode = 2'b00;
    logic [3:0]  in_chan = '0;
    logic [3:0]  in_bank = '0;
    logic [14:0] in_hi = '0;
    logic        out_valid, out_valid_p2;
    logic        out_ready = 1'b1;
    logic [3:0]  out_chan, out_chan_p2;
    logic [4:0]  out_subpart;
    logic [3:0]  out_subpart_p2;
    logic        out_err, out_err_p2;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    // Twelve channels, two sub-partitions each: 32-entry hash space folded to 24.
    part_addr_mapper #(.NUM_CH(12), .SUB_PER_CH(2), .BANK_W(4), .HI_W(15)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_chan(in_chan), .in_bank(in_bank), .in_hi(in_hi),
        .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
        .out_subpart(out_subpart), .out_err(out_err));

    // Sixteen channels, one sub-partition each: power-of-two reference.
    part_addr_mapper #(.NUM_CH(16), .SUB_PER_CH(1), .BANK_W(4), .HI_W(15)) dut_p2 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_p2),
        .in_mode(in_mode), .in_chan(in_chan), .in_bank(in_bank), .in_hi(in_hi),
        .out_valid(out_valid_p2), .out_ready(out_ready), .out_chan(out_chan_p2),
        .out_subpart(out_subpart_p2), .out_err(out_err_p2));

    // {mode, chan, bank, hi, expected err of the 12-channel instance}
    localparam int NV = 14;
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 4'd0,  4'd0, 15'h0000, 1'b0},
        {2'd0, 4'd11, 4'd1, 15'h7FFF, 1'b0},
        {2'd0, 4'd5,  4'd2, 15'h1234, 1'b0},
        {2'd0, 4'd12, 4'd0, 15'h0000, 1'b1},
        {2'd0, 4'd15, 4'd1, 15'h0000, 1'b1},
        {2'd1, 4'd3,  4'd0, 15'h0055, 1'b1},
        {2'd3, 4'd2,  4'd1, 15'h0000, 1'b1},
        {2'd2, 4'd0,  4'd0, 15'h0000, 1'b0},
        {2'd2, 4'd0,  4'd0, 15'h0001, 1'b0},
        {2'd2, 4'd11, 4'd1, 15'h7FFF, 1'b0},
        {2'd2, 4'd7,  4'd0, 15'h2AAA, 1'b0},
        {2'd2, 4'd4,  4'd1, 15'h1555, 1'b0},
        {2'd2, 4'd9,  4'd0, 15'h4000, 1'b0},
        {2'd2, 4'd15, 4'd1, 15'h3C3C, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference sub-partition of the 12-channel instance for modes 00 and 10.
    function automatic logic [4:0] ref_sub(input logic [1:0] m, input logic [3:0] c,
                                           input logic [3:0] b, input logic [14:0] a);
        logic [4:0] id;
        logic [4:0] h;
        id = {c, b[0]};
        if (m != 2'd2) return id;
        h[0] = id[0]^a[0]^a[3]^a[5]^a[6]^a[9]^a[10]^a[11]^a[12]^a[13];
        h[1] = id[1]^a[1]^a[4]^a[6]^a[7]^a[10]^a[11]^a[12]^a[13]^a[14];
        h[2] = id[2]^a[0]^a[2]^a[3]^a[6]^a[7]^a[8]^a[9]^a[10]^a[14];
        h[3] = id[3]^a[1]^a[3]^a[4]^a[7]^a[8]^a[9]^a[10]^a[11];
        h[4] = id[4]^a[2]^a[4]^a[5]^a[8]^a[9]^a[10]^a[11]^a[12];
        if (h >= 5'd24) h = h - 5'd24;
        return h;
    endfunction

    // One request with the consumer ready; returns sampled after the taking edge.
    task automatic send(input logic [1:0] m, input logic [3:0] c,
                        input logic [3:0] b, input logic [14:0] a);
        @(negedge clk);
        in_mode  = m;
        in_chan  = c;
        in_bank  = b;
        in_hi    = a;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [4:0] es;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(out_err == 1'b0, "R1 out_err", int'(out_err), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            logic [1:0]  m;
            logic [3:0]  c, b;
            logic [14:0] a;
            logic        e;
            {m, c, b, a, e} = VEC[v];
            send(m, c, b, a);
            chk(out_valid == 1'b1, "R2 result valid after accept", int'(out_valid), 1);
            chk(out_err == e, "R9 error flag", int'(out_err), int'(e));
            if (m == 2'd0 || m == 2'd2) begin
                es = ref_sub(m, c, b, a);
                chk(out_subpart == es, (m == 2'd0) ? "R4 pass-through" : "R6 hash",
                    int'(out_subpart), int'(es));
                chk(out_chan == es[4:1], "R8 channel from sub-partition",
                    int'(out_chan), int'(es[4:1]));
            end
            // Power-of-two instance: XOR permutation is legal (R5)
            chk(out_err_p2 == (m == 2'd3), "R9 p2 error flag", int'(out_err_p2), int'(m == 2'd3));
            if (m == 2'd0)
                chk(out_subpart_p2 == c, "R4 p2 pass-through", int'(out_subpart_p2), int'(c));
            if (m == 2'd1)
                chk(out_subpart_p2 == (c ^ a[3:0]), "R5 xor permutation",
                    int'(out_subpart_p2), int'(c ^ a[3:0]));
        end

        // Random hash and permutation traffic, R6 R7 R5
        for (int k = 0; k < 200; k++) begin
            logic [3:0]  c, b;
            logic [14:0] a;
            logic [1:0]  m;
            c = 4'($urandom_range(0, 15));
            b = 4'($urandom);
            a = 15'($urandom);
            m = (k % 2 == 0) ? 2'd2 : 2'd1;
            send(m, c, b, a);
            if (m == 2'd2) begin
                es = ref_sub(m, c, b, a);
                chk(out_subpart == es && out_err == 1'b0, "R7 folded hash",
                    int'({out_err, out_subpart}), int'(es));
            end else begin
                chk(out_subpart_p2 == (c ^ a[3:0]) && out_chan_p2 == (c ^ a[3:0]),
                    "R5 random xor", int'(out_subpart_p2), int'(c ^ a[3:0]));
            end
        end

        // R10: power-of-two strides give distinct sub-partitions over one period
        for (int n = 0; n <= 11; n++) begin
            logic [15:0] seen;
            seen = '0;
            for (int j = 0; j < 16; j++) begin
                send(2'd2, 4'd5, 4'd0, 15'(j << n));
                seen[out_subpart_p2] = 1'b1;
            end
            chk(seen == 16'hFFFF, "R10 stride coverage", int'(seen), 16'hFFFF);
        end

        // R2 R3: back-pressure
        @(negedge clk);
        out_ready = 1'b0;
        in_mode = 2'd0; in_chan = 4'd3; in_bank = 4'd1; in_hi = '0; in_valid = 1'b1;
        @(negedge clk);
        in_chan = 4'd6; in_bank = 4'd0;
        chk(in_ready == 1'b0, "R2 in_ready low when stalled", int'(in_ready), 0);
        chk(out_subpart == 5'd7, "R3 first result", int'(out_subpart), 7);
        @(negedge clk);
        chk(out_valid == 1'b1 && out_subpart == 5'd7 && out_chan == 4'd3,
            "R3 hold while stalled", int'(out_subpart), 7);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1 && out_subpart == 5'd12, "R3 second result after release",
            int'(out_subpart), 12);
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 drained", int'(out_valid), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule